// File: doc/BRIEF.md
# Packet Byte Queue With Fill-Level Interrupts

This block is a 128-entry synchronous byte queue that sits between a bit-level framer and a host processor. Each entry holds one data byte plus a marker bit that tags the final byte of a packet. Writer and reader share one clock. The same block serves both directions. In receive use the framer fills it, the host drains it, and the host wants to hear when it is getting full. In transmit use the host fills it, the framer drains it, and the host wants to hear when it is running dry.

Occupancy is tracked by a three-state machine. The states are **ST_EMPTY**, **ST_PART** (holding between one and DEPTH-1 entries) and **ST_FULL**. Its transitions are:
- *fill_first*: ST_EMPTY to ST_PART, on an accepted write.
- *fill_last*: ST_PART to ST_FULL, on a lone write at DEPTH-1 entries.
- *drain_last*: ST_PART to ST_EMPTY, on a lone read at one entry.
- *drain_first*: ST_FULL to ST_PART, on an accepted read.

All other cases hold the current state.

Three sticky event flags sit on top of the queue: the fill threshold, the error flag (overflow or underflow), and end of packet. Each flag has its own enable, and a global enable gates the combined interrupt line. The threshold is chosen with a 3-bit code in steps of 16 entries.

Top module: `pkt_fifo`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0, `fill_cnt`=0), `rd_data`/`rd_last` are 0, all `irq_flags` are 0 and `irq` is 0.
- R2: Bytes are read out in the order written. Each byte comes with the marker bit that was written alongside it. `rd_data`/`rd_last` are registered and show the popped entry in the cycle after an accepted read.
- R3: A write is accepted only when the queue is not full at the start of the cycle. A write while full is dropped, and queue contents and `fill_cnt` are left unchanged by it.
- R4: A read is accepted only when the queue is not empty at the start of the cycle. A read while empty leaves `rd_data` and `rd_last` at their previous values.
- R5: The threshold is T = (thr_code+1)*16. `thr_hit` is `fill_cnt >= T` when `tx_mode`=0 (receive) and `fill_cnt <= T` when `tx_mode`=1 (transmit).
- R6: Flag bit 0 (threshold) is set in the cycle after a cycle in which `thr_hit` was 1.
- R7: Flag bit 1 (error) is set in the cycle after a write while full or a read while empty, in either mode.
- R8: Flag bit 2 (end of packet) is set after an accepted write with `wr_last`=1 when `tx_mode`=0. When `tx_mode`=1 it is set after an accepted read of an entry whose marker is 1.
- R9: Each flag stays set until its `irq_clr` bit is pulsed. A clear in the same cycle as a new event wins, and the flag reads 0 in the next cycle.
- R10: `irq` = `irq_glb_en` AND the OR over i of (`irq_flags[i]` AND `irq_src_en[i]`). It is combinational from the flags.
- R11: `fill_cnt` rises by one per accepted write and falls by one per accepted read. When both are accepted in the same cycle it is unchanged. `full` is set exactly at DEPTH entries and `empty` exactly at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 1 | 0 = receive sense (nearly full), 1 = transmit sense (nearly empty) |
| thr_code | input | 3 | Threshold code N, threshold (N+1)*16 |
| irq_glb_en | input | 1 | Global interrupt enable |
| irq_src_en | input | 3 | Per-flag enables: [0] threshold, [1] error, [2] end of packet |
| irq_clr | input | 3 | Per-flag clear pulses, same bit order |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to write |
| wr_last | input | 1 | Marks the written byte as last of a packet |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Last popped byte |
| rd_last | output | 1 | Marker of last popped byte |
| fill_cnt | output | 8 | Number of entries held |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entries |
| thr_hit | output | 1 | Threshold condition for the current mode |
| irq_flags | output | 3 | Sticky flags: [0] threshold, [1] error, [2] end of packet |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong occupancy state or pointer shows up at the ports quickly. `full`, `empty` or `fill_cnt` deviate from the reference count in the next cycle. A read pointer that has slipped gives a wrong `rd_data` on the very next accepted read. Flag logic faults show up one cycle after the event that should have set or cleared a flag, and `irq` follows in the same cycle because it is combinational. The stimulus spends long periods both at the full boundary and at the empty boundary in each mode, so errors that only appear at the wrap or at the limits are reached.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

    localparam int BYTE_W  = 8;
    localparam int NSRC    = 3;
    localparam int SRC_THR = 0;
    localparam int SRC_ERR = 1;
    localparam int SRC_EOP = 2;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_e;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } entry_t;

endpackage

// File: rtl/pkt_fifo_occ.sv
module pkt_fifo_occ
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [AW-1:0] PTR_LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_NEAR  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);

    occ_state_e state_q, state_d;
    logic [CW-1:0] count_q;
    logic [AW-1:0] wptr_q, rptr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_ok) state_d = ST_PART;            // fill_first
            end
            ST_PART: begin
                if (wr_ok && !rd_ok && count_q == CNT_NEAR)
                    state_d = ST_FULL;                   // fill_last
                else if (rd_ok && !wr_ok && count_q == CNT_ONE)
                    state_d = ST_EMPTY;                  // drain_last
            end
            ST_FULL: begin
                if (rd_ok) state_d = ST_PART;            // drain_first
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        full  = (state_q == ST_FULL);
        empty = (state_q == ST_EMPTY);
        wr_ok = wr_req && (state_q != ST_FULL);
        rd_ok = rd_req && (state_q != ST_EMPTY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            if (wr_ok && !rd_ok)      count_q <= count_q + 1'b1;
            else if (rd_ok && !wr_ok) count_q <= count_q - 1'b1;
            if (wr_ok) wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
            if (rd_ok) rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
        end
    end

    assign count = count_q;
    assign wptr  = wptr_q;
    assign rptr  = rptr_q;

endmodule

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [AW-1:0]     wptr,
    input  entry_t            wr_entry,
    input  logic              rd_ok,
    input  logic [AW-1:0]     rptr,
    output logic              head_last,
    output entry_t            rd_entry
);

    entry_t mem [DEPTH];
    entry_t rd_q;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_entry;
    end

    // output register holds its value when no read is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_ok) rd_q <= mem[rptr];
    end

    assign head_last = mem[rptr].last;
    assign rd_entry  = rd_q;

endmodule

// File: rtl/pkt_fifo_irq.sv
module pkt_fifo_irq
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int STEP  = 16,
    parameter int TW    = 3,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_mode,
    input  logic [TW-1:0]   thr_code,
    input  logic [CW-1:0]   count,
    input  logic            err_ev,
    input  logic            eop_ev,
    input  logic [NSRC-1:0] clr,
    input  logic [NSRC-1:0] src_en,
    input  logic            glb_en,
    output logic            thr_hit,
    output logic [NSRC-1:0] flags,
    output logic            irq
);

    logic [CW-1:0]   thr_val;
    logic [NSRC-1:0] ev;

    always_comb begin
        thr_val = CW'((32'(thr_code) + 32'd1) * 32'(STEP));
        thr_hit = tx_mode ? (count <= thr_val) : (count >= thr_val);
        ev          = '0;
        ev[SRC_THR] = thr_hit;
        ev[SRC_ERR] = err_ev;
        ev[SRC_EOP] = eop_ev;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic f_q;
        always_ff @(posedge clk) begin
            if (!rst_n)     f_q <= 1'b0;
            else if (clr[i]) f_q <= 1'b0;
            else if (ev[i])  f_q <= 1'b1;
        end
        assign flags[i] = f_q;
    end

    assign irq = glb_en && |(flags & src_en);

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int STEP  = 16,
    parameter int TW    = 3,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic [TW-1:0]     thr_code,
    input  logic              irq_glb_en,
    input  logic [NSRC-1:0]   irq_src_en,
    input  logic [NSRC-1:0]   irq_clr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_last,
    output logic [CW-1:0]     fill_cnt,
    output logic              full,
    output logic              empty,
    output logic              thr_hit,
    output logic [NSRC-1:0]   irq_flags,
    output logic              irq
);

    logic          wr_ok, rd_ok, head_last;
    logic [AW-1:0] wptr, rptr;
    entry_t        wr_entry, rd_entry;
    logic          err_ev, eop_ev;

    pkt_fifo_occ #(.DEPTH(DEPTH)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_req(wr_en),
        .rd_req(rd_en),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok),
        .wptr  (wptr),
        .rptr  (rptr),
        .count (fill_cnt),
        .full  (full),
        .empty (empty)
    );

    assign wr_entry = '{last: wr_last, data: wr_data};

    pkt_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .wptr     (wptr),
        .wr_entry (wr_entry),
        .rd_ok    (rd_ok),
        .rptr     (rptr),
        .head_last(head_last),
        .rd_entry (rd_entry)
    );

    assign rd_data = rd_entry.data;
    assign rd_last = rd_entry.last;

    always_comb begin
        err_ev = (wr_en && full) || (rd_en && empty);
        eop_ev = tx_mode ? (rd_ok && head_last) : (wr_ok && wr_last);
    end

    pkt_fifo_irq #(.DEPTH(DEPTH), .STEP(STEP), .TW(TW)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_mode (tx_mode),
        .thr_code(thr_code),
        .count   (fill_cnt),
        .err_ev  (err_ev),
        .eop_ev  (eop_ev),
        .clr     (irq_clr),
        .src_en  (irq_src_en),
        .glb_en  (irq_glb_en),
        .thr_hit (thr_hit),
        .flags   (irq_flags),
        .irq     (irq)
    );

endmodule

// File: rtl/pkt_fifo_chk.sv
module pkt_fifo_chk #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic          rd_last,
    input logic [CW-1:0] fill_cnt,
    input logic          full,
    input logic          empty,
    input logic [2:0]    irq_clr,
    input logic [2:0]    irq_flags
);

    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    // R11: occupancy moves by at most one entry per cycle
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == $past(fill_cnt)) || (fill_cnt == $past(fill_cnt) + 1'b1) ||
        (fill_cnt == $past(fill_cnt) - 1'b1));

    // R11: full and empty never together
    a_r11_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R3: a lone write while full leaves the count at its maximum
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (fill_cnt == CNT_MAX));

    // R4: read while empty keeps the output register
    a_r4_hold_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> ($stable(rd_data) && $stable(rd_last)));

    // R7: overflow attempt raises the error flag unless cleared
    a_r7_err_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !irq_clr[1]) |=> irq_flags[1]);

    // R9: flags remain set without a clear
    a_r9_sticky_err: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[1] && !irq_clr[1]) |=> irq_flags[1]);
    a_r9_sticky_eop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[2] && !irq_clr[2]) |=> irq_flags[2]);

    // R9: clear wins over a simultaneous event
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr[1] |=> !irq_flags[1]);

endmodule

bind pkt_fifo pkt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_last  (rd_last),
    .fill_cnt (fill_cnt),
    .full     (full),
    .empty    (empty),
    .irq_clr  (irq_clr),
    .irq_flags(irq_flags)
);

// File: tb/sim_pkt_fifo.sv
module sim_pkt_fifo;

    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_mode;
    logic [2:0] thr_code;
    logic       irq_glb_en;
    logic [2:0] irq_src_en;
    logic [2:0] irq_clr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       wr_last;
    logic       rd_en;
    logic [7:0] rd_data;
    logic       rd_last;
    logic [7:0] fill_cnt;
    logic       full, empty, thr_hit, irq;
    logic [2:0] irq_flags;

    always #5 clk = ~clk;

    pkt_fifo u0 (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .thr_code(thr_code),
        .irq_glb_en(irq_glb_en), .irq_src_en(irq_src_en), .irq_clr(irq_clr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .rd_en(rd_en),
        .rd_data(rd_data), .rd_last(rd_last), .fill_cnt(fill_cnt),
        .full(full), .empty(empty), .thr_hit(thr_hit),
        .irq_flags(irq_flags), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model
    logic [8:0] mq[$];
    logic [8:0] m_out   = '0;
    logic [2:0] m_flags = '0;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int thr_of(logic [2:0] code);
        return (int'(code) + 1) * 16;
    endfunction

    function automatic bit hit_of(int cnt, logic tx, logic [2:0] code);
        return tx ? (cnt <= thr_of(code)) : (cnt >= thr_of(code));
    endfunction

    task automatic check_all();
        int sz = mq.size();
        chk("R11", "fill_cnt", int'(fill_cnt), sz);
        chk("R11", "full", int'(full), int'(sz == DEPTH));
        chk("R11", "empty", int'(empty), int'(sz == 0));
        chk("R5", "thr_hit", int'(thr_hit), int'(hit_of(sz, tx_mode, thr_code)));
        chk("R2", "rd_data", int'(rd_data), int'(m_out[7:0]));
        chk("R2", "rd_last", int'(rd_last), int'(m_out[8]));
        chk("R9", "irq_flags", int'(irq_flags), int'(m_flags));
        chk("R10", "irq", int'(irq), int'(irq_glb_en && |(m_flags & irq_src_en)));
    endtask

    // one clock: drive at negedge, model at posedge, check at next negedge
    task automatic step(bit we, logic [7:0] wd, bit wl, bit re, logic [2:0] clr);
        bit was_full, was_empty, wok, rok, hit, ev_err, ev_eop;
        logic [8:0] popped;
        wr_en = we; wr_data = wd; wr_last = wl; rd_en = re; irq_clr = clr;
        @(posedge clk);
        was_full  = (mq.size() == DEPTH);
        was_empty = (mq.size() == 0);
        hit = hit_of(mq.size(), tx_mode, thr_code);
        wok = we && !was_full;
        rok = re && !was_empty;
        popped = '0;
        if (rok) begin popped = mq.pop_front(); m_out = popped; end
        if (wok) mq.push_back({wl, wd});
        ev_err = (we && was_full) || (re && was_empty);
        ev_eop = tx_mode ? (rok && popped[8]) : (wok && wl);
        m_flags[0] = clr[0] ? 1'b0 : (m_flags[0] | hit);
        m_flags[1] = clr[1] ? 1'b0 : (m_flags[1] | ev_err);
        m_flags[2] = clr[2] ? 1'b0 : (m_flags[2] | ev_eop);
        @(negedge clk);
        check_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        rst_n = 1'b0; tx_mode = 1'b0; thr_code = 3'd0; irq_glb_en = 1'b1;
        irq_src_en = 3'b111; irq_clr = 3'b000;
        wr_en = 0; wr_data = 0; wr_last = 0; rd_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "fill_cnt", int'(fill_cnt), 0);
        chk("R1", "rd_data", int'(rd_data), 0);
        chk("R1", "irq_flags", int'(irq_flags), 0);
        chk("R1", "irq", int'(irq), 0);

        // R3 R5 R6 R8: receive fill to the top, marker every tenth byte
        thr_code = 3'd2;
        for (int i = 0; i < DEPTH; i++)
            step(1, 8'(i * 3 + 1), (i % 10) == 9, 0, 3'b000);
        chk("R5", "rx threshold reached", int'(irq_flags[0]), 1);
        chk("R8", "rx eop flag", int'(irq_flags[2]), 1);
        chk("R7", "no error before overflow", int'(irq_flags[1]), 0);
        for (int i = 0; i < 4; i++) step(1, 8'hEE, 1, 0, 3'b000);
        chk("R3", "count after overflow", int'(fill_cnt), DEPTH);
        chk("R7", "error after overflow", int'(irq_flags[1]), 1);

        // R9: clear with a simultaneous overflow event, clear wins
        step(1, 8'hEE, 0, 0, 3'b111);
        chk("R9", "err cleared despite event", int'(irq_flags[1]), 0);
        // R10: global disable masks everything
        irq_glb_en = 1'b0;
        step(0, 0, 0, 0, 3'b000);
        chk("R10", "irq masked by global", int'(irq), 0);
        irq_glb_en = 1'b1;

        // R2 R4 R8: transmit drain, then reads while empty
        tx_mode = 1'b1; thr_code = 3'd0;
        step(0, 0, 0, 0, 3'b111);
        for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 3'b000);
        chk("R8", "tx eop flag", int'(irq_flags[2]), 1);
        step(0, 0, 0, 0, 3'b010);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 3'b000);
        chk("R4", "rd_data held", int'(rd_data), int'(8'((DEPTH - 1) * 3 + 1)));
        chk("R7", "error after underflow", int'(irq_flags[1]), 1);

        // random phases
        for (int ph = 0; ph < 24; ph++) begin
            int pw;
            pw = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 15 : 50;
            tx_mode    = ($urandom % 2) == 1;
            thr_code   = 3'($urandom % 8);
            irq_glb_en = ($urandom % 4) != 0;
            irq_src_en = 3'($urandom % 8);
            for (int c = 0; c < 400; c++) begin
                logic [2:0] cl;
                cl = (($urandom % 16) == 0) ? 3'($urandom % 8) : 3'b000;
                step(($urandom % 100) < pw, 8'($urandom), ($urandom % 7) == 0,
                     ($urandom % 100) < (100 - pw), cl);
            end
        end
        finish_run();
    end

endmodule